// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Controller with Row Refresh

This block sits between a simple host request port and a one-bit-wide dynamic memory whose address pins carry the row address and the column address in turn. A host access presents a full address, a write flag and a write bit. The controller drives the upper half of the address onto the shared pins and lowers the row strobe. It then drives the lower half and lowers the column strobe. For reads it captures the returned bit, and it signals completion with a one-cycle `done` pulse.

The controller also keeps the memory alive. An internal row counter names the next row to refresh. A refresh cycle only drives that row and pulses the row strobe, because any access to a row restores every cell in it. A configuration input selects the refresh policy. In distributed mode one row is refreshed at evenly spaced ticks across the retention window. In burst mode, once per window, every row is refreshed back to back and host traffic waits.

The retention window is set in milliseconds and the clock frequency in MHz; the controller converts both into clock cycles. Strobe widths and the minimum precharge gap are parameters measured in clocks.

Top module: `dram_mux_refresh_ctrl`

## Requirements
- R1: After reset, both strobes and the write-enable output are high (inactive), and `host_busy` and `host_done` are low.
- R2: A host access drives the upper half of `host_addr` on `mem_addr` when the row strobe falls. It drives the lower half when the column strobe falls, some cycles later. The column strobe is only ever low while the row strobe is low.
- R3: On a write (`host_wr`=1), `mem_we_n` is low for at least one cycle before the column strobe falls, and `host_wdata` is stored at the addressed cell. On a read, `mem_we_n` stays high and `host_rdata` holds the addressed cell's bit while `host_done` is high.
- R4: `host_done` is high for exactly one cycle per accepted access, and `host_busy` is high in that cycle.
- R5: A request made while `host_busy` is high is not accepted. It starts no memory cycle and changes no cell.
- R6: A refresh cycle pulses the row strobe with the column strobe held high. Refreshed rows follow the order 0, 1, 2, … and wrap to 0 after the last row.
- R7: In distributed mode (`burst_mode`=0), with no host traffic, consecutive refreshes start exactly floor(window cycles / number of rows) cycles apart.
- R8: In burst mode (`burst_mode`=1), every row is refreshed in one run. Consecutive refreshes start T_RAS_REF+T_PRE cycles apart. A host request made during the run is served only after the whole run has finished.
- R9: The row strobe stays high for at least T_PRE cycles between any two low periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 1 selects burst refresh, 0 selects distributed refresh |
| host_req | input | 1 | Access request, taken when the controller is idle and not busy |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Full cell address; upper half is the row, lower half the column |
| host_wdata | input | 1 | Bit to write |
| host_rdata | output | 1 | Bit read, valid with `host_done` |
| host_busy | output | 1 | Access or refresh in progress or pending |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W/2 | Shared row/column address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | 1 | Write data to memory |
| mem_doe | output | 1 | Write data drive enable |
| mem_din | input | 1 | Read data from memory |

## Verification
The bench targets the shared address pins. A controller that swaps the two halves, or lowers the column strobe first, writes to the wrong cell, and the readback of a patterned address table catches it. A second request is raised while an access is in flight; a controller that accepts it would start an extra column cycle and overwrite a cell. Refresh is observed on the memory pins in both policies. An off-by-one refresh timer changes the measured spacing, a row counter that skips or fails to wrap breaks the row order, and a burst that lets a host access in early shortens the run seen before that access. A memory model also measures each row-strobe high gap, so a precharge that is cut short is reported.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_DATA,
        ST_PRE,
        ST_REF
    } drc_state_e;

endpackage

// File: rtl/drc_ref_sched.sv
module drc_ref_sched #(
    parameter int ROW_W   = 11,
    parameter int REF_WIN = 2000000,
    parameter int GAP     = 976
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst,
    input  logic             take,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int ROWS = 1 << ROW_W;
    localparam int CW   = $clog2(REF_WIN + 1);
    localparam int PW   = ROW_W + 2;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [PW-1:0]    pend;
        logic [ROW_W-1:0] row;
    } sched_t;

    sched_t q, d;
    logic [CW-1:0] per;
    logic [PW-1:0] add;
    logic [PW-1:0] sum;
    logic          tick;

    always_comb begin
        d    = q;
        per  = burst ? CW'(REF_WIN - 1) : CW'(GAP - 1);
        tick = (q.cnt >= per);
        d.cnt = tick ? '0 : q.cnt + 1'b1;
        add  = tick ? (burst ? PW'(ROWS) : PW'(1)) : '0;
        sum  = q.pend + add - PW'(take);
        if (sum > PW'(ROWS)) begin
            sum = PW'(ROWS);
        end
        d.pend = sum;
        if (take) begin
            d.row = q.row + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pending = (q.pend != '0);
    assign row     = q.row;

    // R8: the backlog never exceeds one full pass over the rows
    a_r8_pend_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend <= PW'(ROWS));

    // R6: the sequencer only claims a refresh that is owed
    a_r6_take_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pending);

endmodule

// File: rtl/drc_seq.sv
module drc_seq
    import drc_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RAS_REF = 3,
    parameter int T_PRE     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               wr,
    input  logic [2*ROW_W-1:0] addr,
    input  logic               wdata,
    input  logic               ref_pend,
    input  logic [ROW_W-1:0]   ref_row,
    output logic               ref_take,
    output logic               busy,
    output logic               done,
    output logic               rdata,
    output logic [ROW_W-1:0]   mem_addr,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic               dout,
    output logic               doe,
    input  logic               din
);
    localparam int TA   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TB   = (T_RAS_REF > T_PRE) ? T_RAS_REF : T_PRE;
    localparam int TMAX = (TA > TB) ? TA : TB;
    localparam int CW   = $clog2(TMAX + 1);
    localparam int PCW  = $clog2(T_PRE + 1);

    typedef struct packed {
        drc_state_e         st;
        logic [CW-1:0]      cnt;
        logic [2*ROW_W-1:0] adr;
        logic               wr;
        logic               wd;
        logic               rd;
        logic [ROW_W-1:0]   rrow;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d        = q;
        ref_take = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    d.st     = ST_REF;
                    d.cnt    = CW'(T_RAS_REF - 1);
                    d.rrow   = ref_row;
                    ref_take = 1'b1;
                end else if (req) begin
                    d.st  = ST_ROW;
                    d.cnt = CW'(T_RCD - 1);
                    d.adr = addr;
                    d.wr  = wr;
                    d.wd  = wdata;
                end
            end
            ST_ROW: begin
                if (q.cnt == '0) begin
                    d.st  = ST_COL;
                    d.cnt = CW'(T_CAS - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (q.cnt == '0) begin
                    d.st = ST_DATA;
                    if (!q.wr) begin
                        d.rd = din;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_DATA: begin
                d.st  = ST_PRE;
                d.cnt = CW'(T_PRE - 1);
            end
            ST_PRE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (ref_pend) begin
                    d.st     = ST_REF;
                    d.cnt    = CW'(T_RAS_REF - 1);
                    d.rrow   = ref_row;
                    ref_take = 1'b1;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_REF: begin
                if (q.cnt == '0) begin
                    d.st  = ST_PRE;
                    d.cnt = CW'(T_PRE - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ras_n = !(q.st inside {ST_ROW, ST_COL, ST_DATA, ST_REF});
        cas_n = (q.st != ST_COL);
        we_n  = !((q.st inside {ST_ROW, ST_COL}) && q.wr);
        unique case (q.st)
            ST_REF:  mem_addr = q.rrow;
            ST_ROW:  mem_addr = q.adr[2*ROW_W-1:ROW_W];
            default: mem_addr = q.adr[ROW_W-1:0];
        endcase
        dout  = q.wd;
        doe   = (q.st == ST_COL) && q.wr;
        done  = (q.st == ST_DATA);
        busy  = (q.st != ST_IDLE) || ref_pend;
        rdata = q.rd;
    end

    // Counts the cycles the row strobe has been high (checker state)
    logic [PCW-1:0] hi_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q <= PCW'(T_PRE);
        end else if (!ras_n) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != PCW'(T_PRE)) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    a_r2_row_before_col: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!ras_n));

    a_r3_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(we_n));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r6_refresh_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ref_take |=> (!ras_n && cas_n && mem_addr == $past(ref_row)));

    a_r9_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt_q >= PCW'(T_PRE)));

endmodule

// File: rtl/dram_mux_refresh_ctrl.sv
module dram_mux_refresh_ctrl #(
    parameter int ADDR_W    = 22,
    parameter int CLK_MHZ   = 250,
    parameter int REF_MS    = 8,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RAS_REF = 3,
    parameter int T_PRE     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                burst_mode,
    input  logic                host_req,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_wdata,
    output logic                host_rdata,
    output logic                host_busy,
    output logic                host_done,
    output logic [ADDR_W/2-1:0] mem_addr,
    output logic                mem_ras_n,
    output logic                mem_cas_n,
    output logic                mem_we_n,
    output logic                mem_dout,
    output logic                mem_doe,
    input  logic                mem_din
);
    localparam int ROW_W   = ADDR_W / 2;
    localparam int ROWS    = 1 << ROW_W;
    localparam int REF_WIN = REF_MS * CLK_MHZ * 1000;
    localparam int GAP     = REF_WIN / ROWS;

    logic             ref_pend;
    logic             ref_take;
    logic [ROW_W-1:0] ref_row;

    drc_ref_sched #(
        .ROW_W  (ROW_W),
        .REF_WIN(REF_WIN),
        .GAP    (GAP)
    ) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .burst  (burst_mode),
        .take   (ref_take),
        .pending(ref_pend),
        .row    (ref_row)
    );

    drc_seq #(
        .ROW_W    (ROW_W),
        .T_RCD    (T_RCD),
        .T_CAS    (T_CAS),
        .T_RAS_REF(T_RAS_REF),
        .T_PRE    (T_PRE)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (host_req),
        .wr      (host_wr),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .ref_pend(ref_pend),
        .ref_row (ref_row),
        .ref_take(ref_take),
        .busy    (host_busy),
        .done    (host_done),
        .rdata   (host_rdata),
        .mem_addr(mem_addr),
        .ras_n   (mem_ras_n),
        .cas_n   (mem_cas_n),
        .we_n    (mem_we_n),
        .dout    (mem_dout),
        .doe     (mem_doe),
        .din     (mem_din)
    );

endmodule

// File: tb/dram_mux_refresh_ctrl_test.sv
module dram_mux_refresh_ctrl_test;
    localparam int AW    = 8;
    localparam int RW    = AW / 2;
    localparam int TPRE  = 2;
    localparam int TREF  = 3;
    localparam int NROWS = 16;
    localparam int WIN   = 1000;          // 1 ms at the 1 MHz setting
    localparam int GAPX  = WIN / NROWS;   // 62
    localparam int NV    = 10;
    // {write, address, data}
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 8'h00, 1'b1}, {1'b1, 8'hF5, 1'b1}, {1'b1, 8'h5A, 1'b1},
        {1'b1, 8'h3C, 1'b1}, {1'b1, 8'h5A, 1'b0}, {1'b0, 8'h00, 1'b0},
        {1'b0, 8'hF5, 1'b0}, {1'b0, 8'h5A, 1'b0}, {1'b0, 8'h3C, 1'b0},
        {1'b0, 8'hFF, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_mode = 1'b0;
    logic host_req = 1'b0;
    logic host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic host_wdata = 1'b0;
    logic host_rdata, host_busy, host_done;
    logic [RW-1:0] mem_addr;
    logic mem_ras_n, mem_cas_n, mem_we_n, mem_dout, mem_doe, mem_din;

    always #2 clk = ~clk;

    dram_mux_refresh_ctrl #(
        .ADDR_W(AW), .CLK_MHZ(1), .REF_MS(1),
        .T_RCD(2), .T_CAS(2), .T_RAS_REF(TREF), .T_PRE(TPRE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_busy(host_busy), .host_done(host_done),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_din(mem_din)
    );

    // ---------------- behavioural memory and pin monitor ----------------
    logic          mem_m [256];
    logic [RW-1:0] row_m = '0;
    logic [RW-1:0] last_row = '0, last_col = '0, exp_row = '0;
    logic          prev_ras = 1'b1, prev_cas = 1'b1, saw_cas = 1'b0;
    logic          host_between = 1'b1, chk_gap = 1'b0;
    int cyc = 0, hi_cnt = 100, start_t = 0, prev_start = 0;
    int run = 0, last_run = 0, acc_n = 0, ref_n = 0, gap_n = 0;
    int m_checks = 0, m_errors = 0;

    initial for (int i = 0; i < 256; i++) mem_m[i] = 1'b0;

    assign mem_din = mem_m[{row_m, mem_addr}];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            prev_ras <= mem_ras_n;
            prev_cas <= mem_cas_n;
            hi_cnt   <= mem_ras_n ? hi_cnt + 1 : 0;
            if (prev_ras && !mem_ras_n) begin
                row_m   <= mem_addr;
                saw_cas <= 1'b0;
                start_t <= cyc;
                m_checks = m_checks + 1;
                if (hi_cnt < TPRE) begin
                    m_errors = m_errors + 1;
                    $display("FAIL R9 precharge act=%0d exp=%0d", hi_cnt, TPRE);
                end
            end
            if (prev_cas && !mem_cas_n) begin
                m_checks = m_checks + 1;
                if (mem_ras_n) begin
                    m_errors = m_errors + 1;
                    $display("FAIL R2 column strobe without row act=1 exp=0");
                end
                saw_cas      <= 1'b1;
                last_row     <= row_m;
                last_col     <= mem_addr;
                acc_n        <= acc_n + 1;
                last_run     <= run;
                run          <= 0;
                host_between <= 1'b1;
                if (!mem_we_n) begin
                    m_checks = m_checks + 1;
                    if (!mem_doe) begin
                        m_errors = m_errors + 1;
                        $display("FAIL R3 write data not driven act=0 exp=1");
                    end
                    mem_m[{row_m, mem_addr}] <= mem_dout;
                end
            end
            if (!prev_ras && mem_ras_n && !saw_cas) begin
                m_checks = m_checks + 1;
                if (row_m != exp_row) begin
                    m_errors = m_errors + 1;
                    $display("FAIL R6 refresh row act=%0d exp=%0d", row_m, exp_row);
                end
                exp_row <= exp_row + 1'b1;
                ref_n   <= ref_n + 1;
                if (!host_between && (start_t - prev_start) == TREF + TPRE)
                    run <= run + 1;
                else
                    run <= 1;
                if (chk_gap && !host_between) begin
                    gap_n <= gap_n + 1;
                    m_checks = m_checks + 1;
                    if (start_t - prev_start != GAPX) begin
                        m_errors = m_errors + 1;
                        $display("FAIL R7 refresh spacing act=%0d exp=%0d",
                                 start_t - prev_start, GAPX);
                    end
                end
                prev_start   <= start_t;
                host_between <= 1'b0;
            end
        end
    end

    // ---------------- checking helpers ----------------
    int checks = 0, errors = 0;
    logic exp_mem [256];

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic do_access(input logic wr, input logic [AW-1:0] a,
                             input logic wd, output logic rd);
        @(negedge clk);
        while (host_busy) @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = wd;
        do @(negedge clk); while (!host_done);
        rd = host_rdata;
        chk("R4 busy during done", int'(host_busy), 1);
        host_req = 1'b0;
        @(negedge clk);
        chk("R4 done is one cycle", int'(host_done), 0);
    endtask

    initial begin
        logic rd;
        int   a0, r0;
        for (int i = 0; i < 256; i++) exp_mem[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ras_n", int'(mem_ras_n), 1);
        chk("R1 cas_n", int'(mem_cas_n), 1);
        chk("R1 we_n", int'(mem_we_n), 1);
        chk("R1 busy", int'(host_busy), 0);
        chk("R1 done", int'(host_done), 0);

        // Vector table, distributed refresh running underneath (R2, R3)
        for (int v = 0; v < NV; v++) begin
            do_access(VEC[v][9], VEC[v][8:1], VEC[v][0], rd);
            chk("R2 row half", int'(last_row), int'(VEC[v][8:5]));
            chk("R2 column half", int'(last_col), int'(VEC[v][4:1]));
            if (VEC[v][9]) exp_mem[VEC[v][8:1]] = VEC[v][0];
            else chk("R3 read data", int'(rd), int'(exp_mem[VEC[v][8:1]]));
        end

        // R7 distributed spacing with the host idle
        chk_gap = 1'b1;
        r0 = gap_n;
        repeat (320) @(negedge clk);
        chk_gap = 1'b0;
        chk("R7 spacing samples >= 3", int'(gap_n - r0 >= 3), 1);
        chk("R6 refresh count seen", int'(ref_n > 5), 1);

        // R5 request while busy is ignored
        r0 = ref_n;
        while (ref_n == r0) @(negedge clk);
        while (host_busy) @(negedge clk);
        a0 = acc_n;
        host_req = 1'b1; host_wr = 1'b1; host_addr = 8'h11; host_wdata = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        chk("R5 busy after accept", int'(host_busy), 1);
        @(negedge clk);
        host_req = 1'b1; host_addr = 8'h22; host_wdata = 1'b1;
        repeat (2) @(negedge clk);
        host_req = 1'b0;
        while (host_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R5 one column cycle only", acc_n - a0, 1);
        exp_mem[8'h11] = 1'b1;
        do_access(1'b0, 8'h22, 1'b0, rd);
        chk("R5 ignored write left cell", int'(rd), 0);
        do_access(1'b0, 8'h11, 1'b0, rd);
        chk("R3 accepted write stored", int'(rd), 1);

        // R8 burst refresh holds the host off for a full run
        burst_mode = 1'b1;
        repeat (80) @(negedge clk);
        r0 = ref_n;
        while (ref_n == r0) @(negedge clk);
        do_access(1'b0, 8'h3C, 1'b0, rd);
        chk("R8 run length before host", last_run, NROWS);
        chk("R8 read after burst", int'(rd), int'(exp_mem[8'h3C]));
        chk("R6 row counter wrapped", int'(ref_n > NROWS), 1);

        $display("Result: errors=%0d of %0d checks", errors + m_errors, checks + m_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors + m_errors + 1, checks + m_checks + 1);
        $finish;
    end

endmodule